// File: doc/BRIEF.md
# Wait-State Operand Access Sequencer

This block steps through the bus activity of a single instruction. It reads the opcode from memory, spends one cycle on decode, then reads an indirect source operand and an indirect destination operand only if the addressing modes call for them. After one execute cycle it writes the result back through memory, but only when the destination is indirect and the instruction produces a result. It then starts over at the opcode read. The ALU, the register file and the meaning of each instruction belong to the neighbouring logic. That logic supplies three mode flags during decode, the operand addresses and the result word.

A slow device can raise `wait_data` to stretch any stage that touches the bus. While it is high, the sequencer repeats that stage. Decode and execute never touch the bus, so they ignore it. A read strobe or write strobe pulses only in the first cycle of each access. A device that counts accesses therefore sees one event per real access, however long the stage is stretched.

Top module: `opseq_top`

## Requirements
- R1: While reset is low and in the first cycle after it, `stage` is 0 (fetch), `wr_stb` is 0 and `opcode`, `src_val`, `dst_val` and `data_out` are all zero. In that first fetch cycle `rd_stb` is 1.
- R2: The stage codes are fetch 0, decode 1, source read 2, destination read 3, execute 4 and store 5. Stages are visited only in that order. Fetch always goes to decode.
- R3: The flags `src_ind`, `dst_ind` and `dst_wr` are sampled in the decode cycle and select the path. Stage 2 is visited only if `src_ind` is 1. Stage 3 is visited only if `dst_ind` is 1. Stage 5 is visited only if both `dst_ind` and `dst_wr` are 1.
- R4: When `wait_data` is 1 in stage 0, 2, 3 or 5, the same stage repeats on the next cycle. In stages 1 and 4, `wait_data` has no effect and the sequencer always moves on.
- R5: `rd_stb` is 1 only in the first cycle of stages 0, 2 and 3, never while such a stage repeats, and never in stages 1, 4 or 5.
- R6: `wr_stb` is 1 only in the first cycle of stage 5.
- R7: `data_out` takes `result_in` in the execute cycle that leads to stage 5. It then holds that value through the whole store stage and afterwards until the next such load.
- R8: `bus_addr` equals `fetch_addr` in stage 0, `src_addr` in stage 2, and `dst_addr` in stages 3 and 5. In stages 1 and 4 it is zero.
- R9: `data_in` is captured into `opcode` in stage 0, into `src_val` in stage 2 and into `dst_val` in stage 3, each only in a cycle where `wait_data` is 0. At all other times these registers keep their values.
- R10: After execute, the sequencer goes to fetch unless a store is due. After store, it always goes to fetch.
- R11: Cycle counts with no waits: a compare-only instruction with a register source and an indirect destination takes 4 cycles. An instruction with both operands indirect that writes its result takes 6 cycles. A single wait cycle in the destination read makes the 4-cycle case 5 cycles, still with only 2 read strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wait_data | input | 1 | Slow device asks for the current bus stage to repeat |
| src_ind | input | 1 | Source operand is read from memory (sampled in decode) |
| dst_ind | input | 1 | Destination operand is read from memory (sampled in decode) |
| dst_wr | input | 1 | Result is written back to the destination (sampled in decode) |
| fetch_addr | input | AW | Address of the opcode |
| src_addr | input | AW | Address of the indirect source |
| dst_addr | input | AW | Address of the indirect destination |
| data_in | input | DW | Read data from the bus |
| result_in | input | DW | Result word to be stored |
| bus_addr | output | AW | Bus address |
| rd_stb | output | 1 | One pulse per read access |
| wr_stb | output | 1 | One pulse per write access |
| data_out | output | DW | Write data, held through the store stage |
| opcode | output | DW | Captured opcode |
| src_val | output | DW | Captured source operand |
| dst_val | output | DW | Captured destination operand |
| stage | output | 3 | Current stage code |

## Verification
The stage code comes straight out of the state register. A wrong transition therefore shows on `stage` and `bus_addr` in the very next cycle. A wrong first-cycle flag shows at once as a missing strobe, or as a repeated strobe while a stage is stretched. A latched mode flag that is wrong may stay hidden until the cycle after the source read or after execute, where the path splits. A capture enable that ignores `wait_data` only shows when a stretched read returns different data on its last cycle. For that reason the bench changes the read data on every cycle.

// File: rtl/opseq_pkg.sv
package opseq_pkg;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_SRC    = 3'd2,
    ST_DST    = 3'd3,
    ST_EXEC   = 3'd4,
    ST_STORE  = 3'd5
  } stage_e;

  // stage that may be stretched by a slow device
  function automatic logic touches_bus(stage_e s);
    return (s == ST_FETCH) || (s == ST_SRC) || (s == ST_DST) || (s == ST_STORE);
  endfunction

  // successor of a stage that is not being held
  function automatic stage_e advance(stage_e s, logic si, logic di, logic dw);
    stage_e n;
    case (s)
      ST_FETCH:  n = ST_DECODE;
      ST_DECODE: n = si ? ST_SRC : (di ? ST_DST : ST_EXEC);
      ST_SRC:    n = di ? ST_DST : ST_EXEC;
      ST_DST:    n = ST_EXEC;
      ST_EXEC:   n = (di && dw) ? ST_STORE : ST_FETCH;
      default:   n = ST_FETCH;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/opseq_ctrl.sv
module opseq_ctrl
  import opseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wait_data,
  input  logic   src_ind,
  input  logic   dst_ind,
  input  logic   dst_wr,
  output stage_e stage,
  output logic   first_cyc,
  output logic   hold,
  output logic   to_store
);

  logic   si_q, di_q, dw_q;
  logic   si_use, di_use, dw_use;
  stage_e nxt;

  // flags come live from the decoder in decode, latched afterwards
  assign si_use = (stage == ST_DECODE) ? src_ind : si_q;
  assign di_use = (stage == ST_DECODE) ? dst_ind : di_q;
  assign dw_use = (stage == ST_DECODE) ? dst_wr  : dw_q;

  assign hold     = wait_data && touches_bus(stage);
  assign nxt      = hold ? stage : advance(stage, si_use, di_use, dw_use);
  assign to_store = (stage == ST_EXEC) && (nxt == ST_STORE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage     <= ST_FETCH;
      first_cyc <= 1'b1;
      si_q      <= 1'b0;
      di_q      <= 1'b0;
      dw_q      <= 1'b0;
    end else begin
      stage     <= nxt;
      first_cyc <= !hold;
      if (stage == ST_DECODE) begin
        si_q <= src_ind;
        di_q <= dst_ind;
        dw_q <= dst_wr;
      end
    end
  end

  // R4
  held_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_data && touches_bus(stage)) |=> $stable(stage));
  // R4
  no_stall_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == ST_DECODE) |=> (stage != ST_DECODE));
  // R2
  fetch_to_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == ST_FETCH && !wait_data) |=> (stage == ST_DECODE));
  // R10
  store_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == ST_STORE && !wait_data) |=> (stage == ST_FETCH));

endmodule

// File: rtl/opseq_dpath.sv
module opseq_dpath
  import opseq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  stage_e        stage,
  input  logic          first_cyc,
  input  logic          hold,
  input  logic          to_store,
  input  logic [AW-1:0] fetch_addr,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic [DW-1:0] data_in,
  input  logic [DW-1:0] result_in,
  output logic [AW-1:0] bus_addr,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic [DW-1:0] data_out,
  output logic [DW-1:0] opcode,
  output logic [DW-1:0] src_val,
  output logic [DW-1:0] dst_val
);

  logic is_read;
  logic done;

  assign is_read = (stage == ST_FETCH) || (stage == ST_SRC) || (stage == ST_DST);
  assign done    = !hold;
  assign rd_stb  = first_cyc && is_read;
  assign wr_stb  = first_cyc && (stage == ST_STORE);

  always_comb begin
    case (stage)
      ST_FETCH:         bus_addr = fetch_addr;
      ST_SRC:           bus_addr = src_addr;
      ST_DST, ST_STORE: bus_addr = dst_addr;
      default:          bus_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opcode   <= '0;
      src_val  <= '0;
      dst_val  <= '0;
      data_out <= '0;
    end else begin
      if (done && stage == ST_FETCH) opcode  <= data_in;
      if (done && stage == ST_SRC)   src_val <= data_in;
      if (done && stage == ST_DST)   dst_val <= data_in;
      if (to_store)                  data_out <= result_in;
    end
  end

  // R5
  one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && hold) |=> !rd_stb);
  // R6
  wr_only_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (stage == ST_STORE));
  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb));
  // R7
  dout_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == ST_STORE) |=> $stable(data_out));
  // R9
  dst_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage != ST_DST) |=> $stable(dst_val));

endmodule

// File: rtl/opseq_top.sv
module opseq_top
  import opseq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wait_data,
  input  logic          src_ind,
  input  logic          dst_ind,
  input  logic          dst_wr,
  input  logic [AW-1:0] fetch_addr,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic [DW-1:0] data_in,
  input  logic [DW-1:0] result_in,
  output logic [AW-1:0] bus_addr,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic [DW-1:0] data_out,
  output logic [DW-1:0] opcode,
  output logic [DW-1:0] src_val,
  output logic [DW-1:0] dst_val,
  output logic [2:0]    stage
);

  stage_e cur_stage;
  logic   first_cyc;
  logic   hold;
  logic   to_store;

  opseq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wait_data (wait_data),
    .src_ind   (src_ind),
    .dst_ind   (dst_ind),
    .dst_wr    (dst_wr),
    .stage     (cur_stage),
    .first_cyc (first_cyc),
    .hold      (hold),
    .to_store  (to_store)
  );

  opseq_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .stage      (cur_stage),
    .first_cyc  (first_cyc),
    .hold       (hold),
    .to_store   (to_store),
    .fetch_addr (fetch_addr),
    .src_addr   (src_addr),
    .dst_addr   (dst_addr),
    .data_in    (data_in),
    .result_in  (result_in),
    .bus_addr   (bus_addr),
    .rd_stb     (rd_stb),
    .wr_stb     (wr_stb),
    .data_out   (data_out),
    .opcode     (opcode),
    .src_val    (src_val),
    .dst_val    (dst_val)
  );

  assign stage = cur_stage;

endmodule

// File: tb/opseq_top_tb.sv
module opseq_top_tb;
  localparam int AW = 16;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wait_data = 1'b0, src_ind = 1'b0, dst_ind = 1'b0, dst_wr = 1'b0;
  logic [AW-1:0] fetch_addr = '0, src_addr = '0, dst_addr = '0;
  logic [DW-1:0] data_in = '0, result_in = '0;
  logic [AW-1:0] bus_addr;
  logic rd_stb, wr_stb;
  logic [DW-1:0] data_out, opcode, src_val, dst_val;
  logic [2:0] stage;

  always #5 clk = ~clk;

  opseq_top #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wait_data(wait_data),
    .src_ind(src_ind), .dst_ind(dst_ind), .dst_wr(dst_wr),
    .fetch_addr(fetch_addr), .src_addr(src_addr), .dst_addr(dst_addr),
    .data_in(data_in), .result_in(result_in),
    .bus_addr(bus_addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .data_out(data_out), .opcode(opcode), .src_val(src_val),
    .dst_val(dst_val), .stage(stage)
  );

  int n_chk = 0;
  int n_bad = 0;
  int mode = 0;
  bit done = 0;

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int          m_st = 0;
  bit          m_first = 1;
  bit          m_si = 0, m_di = 0, m_dw = 0;
  logic [DW-1:0] m_op = '0, m_src = '0, m_dst = '0, m_out = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_first = 1; m_si = 0; m_di = 0; m_dw = 0;
      m_op = '0; m_src = '0; m_dst = '0; m_out = '0;
    end else begin
      bit stretch;
      int nx;
      stretch = wait_data && (m_st == 0 || m_st == 2 || m_st == 3 || m_st == 5);
      if (!wait_data) begin
        if (m_st == 0) m_op = data_in;
        if (m_st == 2) m_src = data_in;
        if (m_st == 3) m_dst = data_in;
      end
      nx = m_st;
      if (!stretch) begin
        if (m_st == 0) nx = 1;
        else if (m_st == 1) begin
          m_si = src_ind; m_di = dst_ind; m_dw = dst_wr;
          nx = m_si ? 2 : (m_di ? 3 : 4);
        end
        else if (m_st == 2) nx = m_di ? 3 : 4;
        else if (m_st == 3) nx = 4;
        else if (m_st == 4) begin
          if (m_di && m_dw) begin nx = 5; m_out = result_in; end
          else nx = 0;
        end
        else nx = 0;
      end
      m_st = nx;
      m_first = !stretch;
    end
  end

  // per-cycle comparison away from the clock edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [AW-1:0] ea;
      ea = (m_st == 0) ? fetch_addr : (m_st == 2) ? src_addr :
           (m_st == 3 || m_st == 5) ? dst_addr : '0;
      chk("R2/R3/R4/R10 stage", stage, m_st);
      chk("R8 bus_addr", bus_addr, ea);
      chk("R5 rd_stb", rd_stb, m_first && (m_st == 0 || m_st == 2 || m_st == 3));
      chk("R6 wr_stb", wr_stb, m_first && m_st == 5);
      chk("R7 data_out", data_out, m_out);
      chk("R9 opcode", opcode, m_op);
      chk("R9 src_val", src_val, m_src);
      chk("R9 dst_val", dst_val, m_dst);
    end
  end

  // stimulus, 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    fetch_addr <= AW'($urandom);
    src_addr   <= AW'($urandom);
    dst_addr   <= AW'($urandom);
    data_in    <= DW'($urandom);
    result_in  <= DW'($urandom);
    case (mode)
      0: begin
        src_ind <= 1'($urandom); dst_ind <= 1'($urandom); dst_wr <= 1'($urandom);
        wait_data <= ($urandom % 10) < 3;
      end
      1: begin src_ind <= 0; dst_ind <= 1; dst_wr <= 0; wait_data <= 0; end
      2: begin src_ind <= 1; dst_ind <= 1; dst_wr <= 1; wait_data <= 0; end
      default: begin
        src_ind <= 0; dst_ind <= 1; dst_wr <= 0;
        wait_data <= (stage == 3'd3) && rd_stb;
      end
    endcase
  end

  task automatic measure(output int cyc, output int rds, output int wrs);
    do @(negedge clk); while (!(stage == 3'd0 && rd_stb));
    cyc = 0; rds = 0; wrs = 0;
    do begin
      if (rd_stb) rds++;
      if (wr_stb) wrs++;
      cyc++;
      @(negedge clk);
    end while (!(stage == 3'd0 && rd_stb));
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #200000;
    n_bad++;
    done = 1;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    int c, r, w;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 stage in reset", stage, 0);
    chk("R1 wr_stb in reset", wr_stb, 0);
    chk("R1 opcode in reset", opcode, 0);
    chk("R1 dst_val in reset", dst_val, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first fetch stage", stage, 0);
    chk("R1 first fetch read strobe", rd_stb, 1);
    chk("R1 data_out after reset", data_out, 0);

    mode = 0;
    repeat (3000) @(negedge clk);

    mode = 1;
    measure(c, r, w); measure(c, r, w);
    chk("R11 compare-only cycles", c, 4);
    chk("R11 compare-only reads", r, 2);
    chk("R3 compare-only writes", w, 0);

    mode = 2;
    measure(c, r, w); measure(c, r, w);
    chk("R11 full-path cycles", c, 6);
    chk("R11 full-path reads", r, 3);
    chk("R6 full-path writes", w, 1);

    mode = 3;
    measure(c, r, w); measure(c, r, w);
    chk("R11 one-wait cycles", c, 5);
    chk("R11 one-wait reads", r, 2);

    mode = 0;
    repeat (2000) @(negedge clk);
    done = 1;
    summary();
  end

endmodule